// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital half of a 32-tap digitally controlled potentiometer. It keeps the wiper position in a small saturating counter and drives a one-hot tap-select bus. Each bus line closes one analog switch in the resistor string.

Control uses two wires. The first is an active-low select (`sel_n`). The second is a combined direction/step line (`step_ud`). When `sel_n` falls, the level of `step_ud` fixes the direction for the whole selection: high means up, low means down. After that, each rising edge of `step_ud` moves the wiper one tap in that direction. The wiper stops at the two end taps.

While `sel_n` is high, the block is in standby. It ignores `step_ud` and keeps its position, so the next selection starts from the same tap. Both inputs are asynchronous and are brought into the system clock domain before any edge is detected. A sticky flag reports a step-line high or low period that was too short.

Top module: `updown_wiper_ctrl`

## Requirements
- R1: After synchronous reset, `wiper_pos` equals `RESET_POS` (16 by default), `tap_sel` has only bit `RESET_POS` set, `standby` is 1 and `pulse_viol` is 0.
- R2: While `sel_n` is high, `standby` reads 1 and toggling `step_ud` changes neither `wiper_pos` nor `tap_sel`.
- R3: The level of `step_ud` seen at the `sel_n` falling edge sets the direction for that selection: 1 moves up (position increases), 0 moves down (position decreases).
- R4: While selected, each rising edge of `step_ud` changes the position by exactly one tap, and a falling edge leaves it unchanged.
- R5: Stepping up at position `TAPS-1` (31) leaves the position at 31; it never wraps to 0.
- R6: Stepping down at position 0 leaves the position at 0; it never wraps to 31.
- R7: `tap_sel` always has exactly one bit set, and that bit index equals `wiper_pos`.
- R8: The position is kept across deselection, and the next selection resumes from it.
- R9: While selected, a `step_ud` high or low period shorter than `MIN_PULSE` system clocks (30 by default) sets `pulse_viol`. The flag then stays 1 until reset.
- R10: Periods of at least `MIN_PULSE` clocks never set `pulse_viol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select, asynchronous |
| step_ud | input | 1 | Direction level at select, then step clock (rising edge), asynchronous |
| wiper_pos | output | POS_W (5) | Current wiper tap index |
| tap_sel | output | TAPS (32) | One-hot tap switch enables |
| standby | output | 1 | 1 while deselected (synchronized select high) |
| pulse_viol | output | 1 | Sticky short-period flag on the step line |

## Verification
The first sweep steps the wiper upward from midscale past the top tap. It checks the position after every falling and every rising edge, which separates counting on the wrong edge from correct single steps. It also shows whether the counter clamps or wraps at 31. A downward sweep of 40 steps from the top reaches and holds tap 0, which confirms that the direction is latched at select rather than taken from the current line level. Step toggles while deselected, and reselection after a pause, test standby isolation and position retention. Finally, a run of full-width periods followed by one short low period tells a correct threshold apart from a flag that is never set or never sticks.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } wdir_e;
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int          W      = 2,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wpc_front.sv
module wpc_front
  import wpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s_sel_n,
  input  logic s_step,
  output logic inc,
  output logic dec,
  output logic sel_active,
  output logic step_edge
);
  logic  p_sel_n;
  logic  p_step;
  wdir_e dir_q;
  logic  sel_fall;
  logic  step_rise;

  assign sel_fall   = p_sel_n & ~s_sel_n;
  assign sel_active = ~s_sel_n & ~p_sel_n;
  assign step_rise  = sel_active & ~p_step & s_step;
  assign step_edge  = sel_active & (p_step ^ s_step);
  assign inc        = step_rise & (dir_q == DIR_UP);
  assign dec        = step_rise & (dir_q == DIR_DOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_sel_n <= 1'b1;
      p_step  <= 1'b0;
      dir_q   <= DIR_UP;
    end else begin
      p_sel_n <= s_sel_n;
      p_step  <= s_step;
      if (sel_fall) dir_q <= s_step ? DIR_UP : DIR_DOWN;
    end
  end
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
  parameter int TAPS      = 32,
  parameter int RESET_POS = 16,
  localparam int POS_W    = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt
);
  localparam logic [POS_W-1:0] MAX_POS = POS_W'(TAPS - 1);
  localparam logic [POS_W-1:0] INI_POS = POS_W'(RESET_POS);

  always_comb begin
    pos_nxt = pos;
    if (inc && pos != MAX_POS)    pos_nxt = pos + 1'b1;
    else if (dec && pos != '0)    pos_nxt = pos - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= INI_POS;
    else     pos <= pos_nxt;
  end
endmodule

// File: rtl/wpc_decode.sv
module wpc_decode #(
  parameter int TAPS      = 32,
  parameter int RESET_POS = 16,
  localparam int POS_W    = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos_nxt,
  output logic [TAPS-1:0]  tap_sel
);
  logic [TAPS-1:0] hot;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign hot[g] = (pos_nxt == POS_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) tap_sel <= TAPS'(1) << RESET_POS;
    else     tap_sel <= hot;
  end
endmodule

// File: rtl/wpc_pulse_mon.sv
module wpc_pulse_mon #(
  parameter int MIN_PULSE = 30,
  localparam int RL_W     = $clog2(MIN_PULSE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic step_edge,
  output logic viol
);
  localparam logic [RL_W-1:0] RL_MAX = RL_W'(MIN_PULSE);
  logic [RL_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= RL_MAX;
      viol    <= 1'b0;
    end else begin
      if (step_edge) begin
        run_len <= RL_W'(1);
        if (run_len < RL_MAX) viol <= 1'b1;
      end else if (run_len < RL_MAX) begin
        run_len <= run_len + 1'b1;
      end
    end
  end
endmodule

// File: rtl/updown_wiper_ctrl.sv
module updown_wiper_ctrl #(
  parameter int TAPS       = 32,
  parameter int RESET_POS  = 16,
  parameter int MIN_PULSE  = 30,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W     = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             step_ud,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_sel,
  output logic             standby,
  output logic             pulse_viol
);
  logic [1:0]       s_in;
  logic             inc, dec, sel_active, step_edge;
  logic [POS_W-1:0] pos_nxt;

  wpc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({sel_n, step_ud}), .q(s_in)
  );

  wpc_front u_front (
    .clk(clk), .rst(rst), .s_sel_n(s_in[1]), .s_step(s_in[0]),
    .inc(inc), .dec(dec), .sel_active(sel_active), .step_edge(step_edge)
  );

  wpc_counter #(.TAPS(TAPS), .RESET_POS(RESET_POS)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .dec(dec), .pos(wiper_pos), .pos_nxt(pos_nxt)
  );

  wpc_decode #(.TAPS(TAPS), .RESET_POS(RESET_POS)) u_dec (
    .clk(clk), .rst(rst), .pos_nxt(pos_nxt), .tap_sel(tap_sel)
  );

  wpc_pulse_mon #(.MIN_PULSE(MIN_PULSE)) u_mon (
    .clk(clk), .rst(rst), .step_edge(step_edge), .viol(pulse_viol)
  );

  assign standby = s_in[1];
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int TAPS  = 32,
  localparam int POS_W = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst,
  input logic [POS_W-1:0] wiper_pos,
  input logic [TAPS-1:0]  tap_sel,
  input logic             standby,
  input logic             pulse_viol
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (rst || !armed)
    $countones(tap_sel) == 1); // R7
  AST_TAP_MATCH: assert property (@(posedge clk) disable iff (rst || !armed)
    tap_sel[wiper_pos]); // R7
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
    (wiper_pos != $past(wiper_pos)) |->
      (wiper_pos == $past(wiper_pos) + 1'b1 || wiper_pos == $past(wiper_pos) - 1'b1)); // R4
  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(standby) |-> $stable(wiper_pos)); // R2
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wiper_pos) == POS_W'(TAPS - 1)) |-> (wiper_pos != '0)); // R5
  AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wiper_pos) == '0) |-> (wiper_pos != POS_W'(TAPS - 1))); // R6
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(pulse_viol) |-> pulse_viol); // R9
endmodule

bind updown_wiper_ctrl wpc_checker #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .wiper_pos(wiper_pos), .tap_sel(tap_sel),
  .standby(standby), .pulse_viol(pulse_viol)
);

// File: tb/sim_updown_wiper_ctrl.sv
module sim_updown_wiper_ctrl;
  localparam int TAPS = 32;
  localparam int HALF = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1;
  logic        step_ud = 1'b0;
  logic [4:0]  wiper_pos;
  logic [31:0] tap_sel;
  logic        standby;
  logic        pulse_viol;

  int checks = 0;
  int errors = 0;
  int exp_pos = 16;
  bit dir_up  = 1'b1;

  always #5 clk = ~clk;

  updown_wiper_ctrl u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .step_ud(step_ud),
    .wiper_pos(wiper_pos), .tap_sel(tap_sel), .standby(standby), .pulse_viol(pulse_viol)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic chk_pos(input string req);
    chk(req, int'(wiper_pos), exp_pos);
    chk({req, "/R7 tap_sel"}, (tap_sel == (32'd1 << exp_pos)) ? 1 : 0, 1);
  endtask

  task automatic do_select(input bit up);
    step_ud = up;
    wait_cyc(6);
    sel_n = 1'b0;
    dir_up = up;
    wait_cyc(6);
  endtask

  task automatic do_deselect();
    wait_cyc(4);
    sel_n = 1'b1;
    wait_cyc(6);
  endtask

  // one rising edge per call; the low phase is checked for no movement (R4)
  task automatic step_once(input int low_len);
    step_ud = 1'b0;
    wait_cyc(low_len);
    chk_pos("R4 falling edge");
    step_ud = 1'b1;
    wait_cyc(HALF);
    if (dir_up) exp_pos = (exp_pos < TAPS - 1) ? exp_pos + 1 : exp_pos;
    else        exp_pos = (exp_pos > 0) ? exp_pos - 1 : exp_pos;
    chk_pos("R3/R4/R5/R6 step");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    // R1 reset state
    chk_pos("R1 reset");
    chk("R1 standby", int'(standby), 1);
    chk("R1 viol", int'(pulse_viol), 0);

    // R2 toggles while deselected
    for (int i = 0; i < 5; i++) begin
      step_ud = 1'b1; wait_cyc(HALF);
      step_ud = 1'b0; wait_cyc(HALF);
    end
    chk_pos("R2 standby ignore");
    chk("R2 standby", int'(standby), 1);

    // R3/R5 up sweep past top
    do_select(1'b1);
    chk("R2 selected", int'(standby), 0);
    for (int i = 0; i < 20; i++) step_once(HALF);
    chk("R5 top", int'(wiper_pos), 31);

    // R8 hold across deselect, then R6 down sweep
    do_deselect();
    chk_pos("R8 hold");
    do_select(1'b0);
    chk_pos("R8 resume");
    for (int i = 0; i < 40; i++) step_once(HALF);
    chk("R6 bottom", int'(wiper_pos), 0);

    do_deselect();
    do_select(1'b1);
    for (int i = 0; i < 3; i++) step_once(HALF);
    chk("R8 from zero", int'(wiper_pos), 3);
    chk("R10 no viol", int'(pulse_viol), 0);

    // R9 short low period
    step_once(10);
    chk("R9 viol set", int'(pulse_viol), 1);
    do_deselect();
    do_select(1'b0);
    for (int i = 0; i < 2; i++) step_once(HALF);
    chk("R9 sticky", int'(pulse_viol), 1);
    do_deselect();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule